// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the device side of a legacy configuration interface reached over an 8-bit I/O bus. The host reaches it through two byte-wide ports, an index port and a data port. The host first writes a four-byte key to the index port. Only after the full key does the block open its configuration space. Each access is then a pair of steps: the host writes a register number to the index port, then reads or writes the value on the data port.

One register selects the logical device. When that selector holds the GPIO device number, a 16-bit GPIO I/O base address can be read and written. The block also serves a fixed chip identifier and a revision byte. Writing the leave command returns the block to its locked state. While locked, the configuration space is invisible to the host.

Top module: `cfg_port_ctrl`

## Requirements
- R1: After reset the block is locked (`cfg_mode_o`=0), the logical device selector is 0x00, the latched index is 0x00, `gpio_base_o` equals the `GPIO_BASE_RST` parameter and `io_rdata` is 0xFF.
- R2: While locked, writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (address 0x2E) sets `cfg_mode_o` in the cycle after the fourth write; a partial key leaves it clear.
- R3: A byte that breaks the key restarts the match, except that a 0x87 byte counts at once as the first key byte.
- R4: While unlocked, a data-port write (address 0x2F) with index 0x02 and bit 1 of the data set clears `cfg_mode_o` in the next cycle; any other value written there keeps the block unlocked.
- R5: While locked, data-port reads and index-port reads return 0xFF, data-port writes change no register, and index-port writes feed only the key matcher and not the index.
- R6: While unlocked, an index-port write latches the register number. A read strobe on the data port then puts that register's value on `io_rdata` one cycle later, and `io_rdata` holds it until the next read. An index-port read returns the latched index.
- R7: Register 0x07 is the logical device selector. It is readable and writable, and its value is shown on `ldn_o`.
- R8: Registers 0x20 and 0x21 return the high and low bytes of `CHIP_ID`, and register 0x22 returns `CHIP_REV` in bits 3:0 with bits 7:4 zero. Writes to these three registers change nothing.
- R9: With the selector at 0x07 (GPIO device), registers 0x62 (high byte) and 0x63 (low byte) read and write the GPIO base address shown on `gpio_base_o`. Under any other selector they read 0x00 and writes are ignored.
- R10: Bus cycles at addresses other than 0x2E and 0x2F change no state and leave `io_rdata` unchanged. Unassigned register numbers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address of the current bus cycle |
| io_wr | input | 1 | One-cycle write strobe |
| io_rd | input | 1 | One-cycle read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, held between reads |
| cfg_mode_o | output | 1 | High while configuration space is unlocked |
| ldn_o | output | 8 | Current logical device selector |
| gpio_base_o | output | 16 | GPIO I/O base address register |

## Verification
Every state change, including unlock, leave, index latch, selector and base-address updates, takes effect at the clock edge that samples the write strobe. Read data appears on `io_rdata` at the edge that samples the read strobe. Each bench task drives a strobe for exactly one cycle, starting at a falling edge. It removes the strobe at the next falling edge and samples there. That sampling point lies half a cycle after the one edge where the result lands, so every check sees the value due exactly one cycle after its stimulus. Partial-key checks sample `cfg_mode_o` after each single write, which shows that it does not move early.

// File: rtl/cfg_port_pkg.sv
// Package: shared constants for the configuration port controller.
// Assumes 8-bit configuration registers and a fixed four-byte unlock key.
package cfg_port_pkg;

    localparam int KEY_LEN = 4;

    localparam logic [7:0] IDX_EXIT    = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_BASE_HI = 8'h62;
    localparam logic [7:0] LDN_GPIO    = 8'h07;
    localparam logic [7:0] BYTE_IDLE   = 8'hFF;

    // Key byte at position pos of the unlock sequence.
    function automatic logic [7:0] key_byte(input int pos);
        case (pos)
            0:       key_byte = 8'h87;
            1:       key_byte = 8'h01;
            default: key_byte = 8'h55;
        endcase
    endfunction

endpackage

// File: rtl/cfg_key_unlock.sv
// Module: cfg_key_unlock
// Tracks the unlock key written to the index port while locked.
// Assumes byte_valid is only raised for index-port writes in locked mode.
// unlock_o is combinational and marks the write that completes the key.
module cfg_key_unlock
    import cfg_port_pkg::*;
#(
    parameter int SEQ_LEN = KEY_LEN
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       unlock_o
);
    localparam int CNT_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0]   pos_q;
    logic [SEQ_LEN-1:0] hit;
    logic               cur_hit;

    // One comparator per key position.
    for (genvar g = 0; g < SEQ_LEN; g++) begin : g_cmp
        assign hit[g] = (byte_in == key_byte(g));
    end

    // Select the comparator for the expected position.
    assign cur_hit  = hit[pos_q];
    assign unlock_o = byte_valid && cur_hit && (pos_q == LAST);

    // Advance, restart or re-seed the match position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (byte_valid) begin
            if (cur_hit) begin
                pos_q <= (pos_q == LAST) ? '0 : pos_q + ONE;
            end else if (hit[0]) begin
                pos_q <= ONE;
            end else begin
                pos_q <= '0;
            end
        end
    end

    AST_KEY_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_in == 8'h87 && !unlock_o) |=> (pos_q == ONE)); // R3

endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// Configuration registers: device selector, chip identity and the banked
// GPIO base address. Assumes wr_en is only raised in unlocked mode.
// Read data is combinational from the latched index.
module cfg_reg_bank
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] CHIP_ID       = 16'hA51C,
    parameter logic [3:0]  CHIP_REV      = 4'h3,
    parameter int          BASE_W        = 16,
    parameter logic [BASE_W-1:0] BASE_RST = BASE_W'(16'h0A00)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        index,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [7:0]        ldn_o,
    output logic [BASE_W-1:0] gpio_base_o
);
    localparam int BASE_BYTES = BASE_W / 8;

    logic [7:0]        ldn_q;
    logic [BASE_W-1:0] base_q;
    logic              gpio_sel;

    assign gpio_sel    = (ldn_q == LDN_GPIO);
    assign ldn_o       = ldn_q;
    assign gpio_base_o = base_q;

    // Update selector and banked base-address bytes, high byte first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q  <= 8'h00;
            base_q <= BASE_RST;
        end else if (wr_en) begin
            if (index == IDX_LDN) ldn_q <= wr_data;
            for (int k = 0; k < BASE_BYTES; k++) begin
                if (gpio_sel && index == 8'(IDX_BASE_HI + k))
                    base_q[(BASE_BYTES-1-k)*8 +: 8] <= wr_data;
            end
        end
    end

    // Read multiplexer over fixed and banked registers.
    always_comb begin
        rd_data = 8'h00;
        case (index)
            IDX_LDN:   rd_data = ldn_q;
            IDX_ID_HI: rd_data = CHIP_ID[15:8];
            IDX_ID_LO: rd_data = CHIP_ID[7:0];
            IDX_REV:   rd_data = {4'h0, CHIP_REV};
            default:   rd_data = 8'h00;
        endcase
        for (int k = 0; k < BASE_BYTES; k++) begin
            if (gpio_sel && index == 8'(IDX_BASE_HI + k))
                rd_data = base_q[(BASE_BYTES-1-k)*8 +: 8];
        end
    end

    AST_BASE_FOREIGN_LDN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ldn_q != LDN_GPIO) |=> $stable(base_q)); // R9

endmodule

// File: rtl/cfg_port_ctrl.sv
// Module: cfg_port_ctrl (top)
// Decodes the index and data ports from the I/O bus, holds the lock state
// and the latched index, and registers read data. Assumes one-cycle
// strobes; a bus cycle outside the two ports is ignored.
module cfg_port_ctrl
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'(16'h002E),
    parameter logic [ADDR_W-1:0] DATA_PORT  = ADDR_W'(16'h002F),
    parameter logic [15:0] CHIP_ID       = 16'hA51C,
    parameter logic [3:0]  CHIP_REV      = 4'h3,
    parameter logic [15:0] GPIO_BASE_RST = 16'h0A00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_mode_o,
    output logic [7:0]        ldn_o,
    output logic [15:0]       gpio_base_o
);
    logic       idx_hit, dat_hit;
    logic       mode_q;
    logic [7:0] index_q;
    logic       key_valid, unlock, exit_req, bank_wr;
    logic [7:0] bank_rd;

    assign idx_hit    = (io_addr == INDEX_PORT);
    assign dat_hit    = (io_addr == DATA_PORT);
    assign key_valid  = io_wr && idx_hit && !mode_q;
    assign bank_wr    = io_wr && dat_hit && mode_q;
    assign exit_req   = bank_wr && (index_q == IDX_EXIT) && io_wdata[1];
    assign cfg_mode_o = mode_q;

    cfg_key_unlock #(.SEQ_LEN(KEY_LEN)) u_key (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (key_valid),
        .byte_in    (io_wdata),
        .unlock_o   (unlock)
    );

    cfg_reg_bank #(
        .CHIP_ID  (CHIP_ID),
        .CHIP_REV (CHIP_REV),
        .BASE_W   (16),
        .BASE_RST (GPIO_BASE_RST)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bank_wr),
        .index       (index_q),
        .wr_data     (io_wdata),
        .rd_data     (bank_rd),
        .ldn_o       (ldn_o),
        .gpio_base_o (gpio_base_o)
    );

    // Lock state: open on a completed key, close on the leave command.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= 1'b0;
        else if (unlock)   mode_q <= 1'b1;
        else if (exit_req) mode_q <= 1'b0;
    end

    // Latch the register number from index-port writes while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                        index_q <= 8'h00;
        else if (io_wr && idx_hit && mode_q) index_q <= io_wdata;
    end

    // Register read data on a port read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rdata <= BYTE_IDLE;
        end else if (io_rd && dat_hit) begin
            io_rdata <= mode_q ? bank_rd : BYTE_IDLE;
        end else if (io_rd && idx_hit) begin
            io_rdata <= mode_q ? index_q : BYTE_IDLE;
        end
    end

    AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q) |-> $past(io_wr && idx_hit && io_wdata == 8'h55)); // R2
    AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q) |-> $past(io_wr && dat_hit && index_q == IDX_EXIT && io_wdata[1])); // R4
    AST_LOCKED_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && dat_hit && !mode_q) |=> (io_rdata == 8'hFF)); // R5
    AST_LDN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |=> $stable(ldn_o)); // R5
    AST_INDEX_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |=> $stable(index_q)); // R5
    AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_hit || dat_hit) |=> $stable(io_rdata)); // R10

endmodule

// File: tb/tb_cfg_port_ctrl.sv
module tb_cfg_port_ctrl;
    localparam time CLK_HALF = 10ns; // 50 MHz
    localparam logic [15:0] IP = 16'h002E;
    localparam logic [15:0] DP = 16'h002F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_mode_o;
    logic [7:0]  ldn_o;
    logic [15:0] gpio_base_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #CLK_HALF clk = ~clk;

    cfg_port_ctrl dut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_mode_o(cfg_mode_o), .ldn_o(ldn_o), .gpio_base_o(gpio_base_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk); io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a);
        @(negedge clk); io_addr = a; io_rd = 1'b1;
        @(negedge clk); io_rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        bus_wr(IP, idx); bus_wr(DP, d);
    endtask

    task automatic reg_rd(input logic [7:0] idx);
        bus_wr(IP, idx); bus_rd(DP);
    endtask

    task automatic send_key();
        bus_wr(IP, 8'h87); bus_wr(IP, 8'h01); bus_wr(IP, 8'h55); bus_wr(IP, 8'h55);
    endtask

    task automatic t_reset();
        chk("R1 mode", 16'(cfg_mode_o), 16'h0);
        chk("R1 ldn", 16'(ldn_o), 16'h00);
        chk("R1 base", gpio_base_o, 16'h0A00);
        chk("R1 rdata", 16'(io_rdata), 16'hFF);
    endtask

    task automatic t_locked();
        bus_rd(DP);       chk("R5 locked data read", 16'(io_rdata), 16'hFF);
        bus_wr(IP, 8'h07);
        bus_wr(DP, 8'h07);
        chk("R5 locked write ldn", 16'(ldn_o), 16'h00);
        bus_rd(IP);       chk("R5 locked index read", 16'(io_rdata), 16'hFF);
    endtask

    task automatic t_unlock();
        bus_wr(IP, 8'h87); chk("R2 partial1", 16'(cfg_mode_o), 16'h0);
        bus_wr(IP, 8'h01); chk("R2 partial2", 16'(cfg_mode_o), 16'h0);
        bus_wr(IP, 8'h55); chk("R2 partial3", 16'(cfg_mode_o), 16'h0);
        bus_wr(IP, 8'h55); chk("R2 full key", 16'(cfg_mode_o), 16'h1);
        bus_rd(IP);        chk("R1 index zero", 16'(io_rdata), 16'h00);
    endtask

    task automatic t_ident();
        reg_rd(8'h20); chk("R8 R6 id hi", 16'(io_rdata), 16'hA5);
        reg_rd(8'h21); chk("R8 id lo", 16'(io_rdata), 16'h1C);
        reg_rd(8'h22); chk("R8 rev", 16'(io_rdata), 16'h03);
        reg_wr(8'h22, 8'hFF); bus_rd(DP); chk("R8 rev write ignored", 16'(io_rdata), 16'h03);
        reg_wr(8'h20, 8'h00); bus_rd(DP); chk("R8 id write ignored", 16'(io_rdata), 16'hA5);
        bus_rd(IP); chk("R6 index readback", 16'(io_rdata), 16'h20);
    endtask

    task automatic t_ldn_base();
        reg_wr(8'h07, 8'h07); chk("R7 ldn out", 16'(ldn_o), 16'h07);
        bus_rd(DP);           chk("R7 ldn read", 16'(io_rdata), 16'h07);
        reg_wr(8'h62, 8'h12);
        reg_wr(8'h63, 8'h34); chk("R9 base out", gpio_base_o, 16'h1234);
        reg_rd(8'h62);        chk("R9 base hi", 16'(io_rdata), 16'h12);
        reg_rd(8'h63);        chk("R9 base lo", 16'(io_rdata), 16'h34);
        reg_wr(8'h07, 8'h05); chk("R7 ldn change", 16'(ldn_o), 16'h05);
        reg_rd(8'h62);        chk("R9 foreign ldn read", 16'(io_rdata), 16'h00);
        reg_wr(8'h62, 8'h99); chk("R9 foreign ldn write", gpio_base_o, 16'h1234);
        reg_wr(8'h07, 8'h07);
        reg_rd(8'h62);        chk("R9 base kept", 16'(io_rdata), 16'h12);
    endtask

    task automatic t_foreign();
        reg_rd(8'h40);        chk("R10 unassigned reads zero", 16'(io_rdata), 16'h00);
        reg_rd(8'h21);
        bus_wr(16'h0080, 8'h33);
        bus_rd(16'h0080);     chk("R10 foreign read holds", 16'(io_rdata), 16'h1C);
        bus_rd(IP);           chk("R10 index unchanged", 16'(io_rdata), 16'h21);
        chk("R10 ldn unchanged", 16'(ldn_o), 16'h07);
    endtask

    task automatic t_exit();
        reg_wr(8'h02, 8'h01); chk("R4 no exit on 0x01", 16'(cfg_mode_o), 16'h1);
        bus_wr(DP, 8'h02);    chk("R4 exit on 0x02", 16'(cfg_mode_o), 16'h0);
        bus_rd(DP);           chk("R5 read after exit", 16'(io_rdata), 16'hFF);
        chk("R7 ldn kept", 16'(ldn_o), 16'h07);
    endtask

    task automatic t_restart();
        bus_wr(IP, 8'h87); bus_wr(IP, 8'h01); bus_wr(IP, 8'h87);
        bus_wr(IP, 8'h01); bus_wr(IP, 8'h55);
        chk("R3 reseed partial", 16'(cfg_mode_o), 16'h0);
        bus_wr(IP, 8'h55); chk("R3 reseed mid-key", 16'(cfg_mode_o), 16'h1);
        reg_wr(8'h02, 8'h02);
        bus_wr(IP, 8'h87); bus_wr(IP, 8'h01); bus_wr(IP, 8'h55);
        bus_wr(IP, 8'h33); bus_wr(IP, 8'h55);
        chk("R3 broken key", 16'(cfg_mode_o), 16'h0);
        bus_wr(IP, 8'h87); bus_wr(IP, 8'h87); bus_wr(IP, 8'h01);
        bus_wr(IP, 8'h55); bus_wr(IP, 8'h55);
        chk("R3 double first byte", 16'(cfg_mode_o), 16'h1);
        reg_wr(8'h02, 8'h02);
        send_key(); chk("R2 key again", 16'(cfg_mode_o), 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_unlock();
        t_ident();
        t_ldn_base();
        t_foreign();
        t_exit();
        t_restart();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule